// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a watchdog countdown timer that is already running when any reset ends. It counts up on a slow timer clock. When the count passes its top value, it raises a system reset request and reloads. Software on a register bus can stop the count only with an ordered pair of key words written to the key register. A second ordered pair starts the count again. Each key write crosses from the bus clock into the timer clock through a toggle handshake. Software polls a pending flag to learn when the write has taken effect. While the flag is set, further key writes are dropped.

A soft-reset control re-arms the timer from any state and reloads the default reload value. A done flag reports when the timer side has finished its fixed reset window. The reload register sets the count value loaded after each overflow. The count therefore repeats every 2^32 minus the reload value timer cycles.

Bus accesses complete in one cycle. A read returns its data on `bus_rdata` one bus clock after the access. Accesses to offsets not listed below read as zero, and writes to them are ignored.

Top module: `wdt_keyed`

## Requirements
- R1: After hardware reset, with no software action, `wdt_reset_req` pulses within 2^32 minus the reset reload value timer cycles. With the default reload value of 0xFFFF_FF00, this is 256 cycles.
- R2: Writing 0xAAAA and then 0x5555 to the key register at offset 0x48 stops the count. Software waits for the pending flag to clear after each of the two writes. Once stopped, no reset request is produced.
- R3: If the word accepted right after 0xAAAA is not 0x5555, the sequence is abandoned and the enable state is unchanged. A following lone 0x5555 does not stop the count.
- R4: Bit 4 of the status register at offset 0x34 reads 1 in the read right after an accepted key write. It returns to 0 once the write has taken effect, and it reads 0 after reset.
- R5: A key write that arrives while bit 4 of offset 0x34 is 1 is dropped.
- R6: Writing 1 to bit 1 of the control register at offset 0x10 starts a soft reset. Bit 0 of the status register at offset 0x14 reads 0 in the read right after that write and later reads 1. Bit 0 of offset 0x14 reads 1 after hardware reset. The soft reset restores the reload register to 0xFFFF_FF00 and re-arms the count even if it was stopped, so a reset request follows.
- R7: Each reset request is one timer cycle wide. Requests repeat every 2^32 minus the reload value timer cycles, which is 256 cycles for the default reload value.
- R8: Writing 0xBBBB and then 0x4444 to offset 0x48, with a poll of the pending flag after each write, restarts a stopped count.
- R9: The reload register at offset 0x2C reads 0xFFFF_FF00 after reset and reads back the value written to it. A written value takes effect at the next overflow: after writing 0xFFFF_FFC0, requests repeat every 64 timer cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset for both clock domains |
| tclk | input | 1 | Timer clock |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read access |
| wdt_reset_req | output | 1 | One-timer-cycle system reset request on overflow |

## Verification
The hardest case to reach is a key write that lands while the previous key write is still crossing into the timer clock. To reach it, the stimulus issues 0xAAAA and 0x5555 on consecutive bus cycles without polling, so the second word is dropped. The bench then writes a non-key word to clear the half-entered sequence and confirms that requests continue. A second hard case is a soft reset issued while the timer is stopped. The bench first stops the count with the key pair, then fires the soft reset. It checks that the done flag drops and rises, that the reload value returns to its default, and that requests resume at the default spacing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h10;
  localparam logic [7:0] ADDR_STAT = 8'h14;
  localparam logic [7:0] ADDR_LOAD = 8'h2C;
  localparam logic [7:0] ADDR_PEND = 8'h34;
  localparam logic [7:0] ADDR_KEY  = 8'h48;

  localparam int SRST_BIT  = 1;
  localparam int DONE_BIT  = 0;
  localparam int PEND_BIT  = 4;

  localparam logic [15:0] KEY_STOP_A = 16'hAAAA;
  localparam logic [15:0] KEY_STOP_B = 16'h5555;
  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_STOP = 2'd1,
    KS_RUN  = 2'd2
  } key_state_t;
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 8,
  parameter logic [31:0] LOAD_RESET = 32'hFFFF_FF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          key_tgl,
  output logic [DW-1:0] key_data,
  input  logic          key_ack_s,
  output logic          srst_tgl,
  input  logic          srst_ack_s,
  output logic [DW-1:0] load_q
);
  logic wr_acc, rd_acc, wr_key, wr_ctrl, wr_load;
  logic key_pend, srst_done;
  logic [DW-1:0] rd_mux;

  assign wr_acc    = bus_sel & bus_we;
  assign rd_acc    = bus_sel & ~bus_we;
  assign wr_key    = wr_acc && (bus_addr == AW'(ADDR_KEY));
  assign wr_ctrl   = wr_acc && (bus_addr == AW'(ADDR_CTRL));
  assign wr_load   = wr_acc && (bus_addr == AW'(ADDR_LOAD));
  assign key_pend  = key_tgl ^ key_ack_s;
  assign srst_done = (srst_tgl == srst_ack_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_tgl  <= 1'b0;
      key_data <= '0;
    end else if (wr_key && !key_pend) begin
      key_tgl  <= ~key_tgl;
      key_data <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_tgl <= 1'b0;
      load_q   <= DW'(LOAD_RESET);
    end else if (wr_ctrl && bus_wdata[SRST_BIT] && srst_done) begin
      srst_tgl <= ~srst_tgl;
      load_q   <= DW'(LOAD_RESET);
    end else if (wr_load) begin
      load_q   <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(ADDR_STAT): rd_mux[DONE_BIT] = srst_done;
      AW'(ADDR_PEND): rd_mux[PEND_BIT] = key_pend;
      AW'(ADDR_LOAD): rd_mux = load_q;
      AW'(ADDR_KEY):  rd_mux = key_data;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  // R4: an accepted key write leaves the pending flag raised
  p_pend_on_key_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && !key_pend) |=> key_pend);

  // R5: a key write during a pending transfer leaves the held word alone
  p_busy_key_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && key_pend) |=> $stable(key_data));

  // R6: reset-done drops right after a soft-reset request
  p_rdone_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[SRST_BIT] && srst_done) |=> !srst_done);
endmodule

// File: rtl/wdt_timer_core.sv
module wdt_timer_core
  import wdt_pkg::*;
#(
  parameter int          DW          = 32,
  parameter logic [31:0] LOAD_RESET  = 32'hFFFF_FF00,
  parameter int          SRST_CYCLES = 4
) (
  input  logic          tclk,
  input  logic          rst_n,
  input  logic          key_tgl_s,
  input  logic [DW-1:0] key_data,
  output logic          key_ack,
  input  logic          srst_tgl_s,
  output logic          srst_ack,
  input  logic [DW-1:0] load_s,
  output logic          rst_req
);
  localparam int SCW = $clog2(SRST_CYCLES + 1);

  logic           key_seen, srst_seen;
  logic           key_evt, srst_evt, busy;
  logic [SCW-1:0] sc_q;
  logic [DW-1:0]  cnt_q;
  logic           en_q;
  key_state_t     ks_q;

  assign key_evt  = key_tgl_s ^ key_seen;
  assign srst_evt = srst_tgl_s ^ srst_seen;
  assign busy     = (sc_q != '0);
  assign key_ack  = key_seen;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      key_seen  <= 1'b0;
      srst_seen <= 1'b0;
    end else begin
      key_seen  <= key_tgl_s;
      srst_seen <= srst_tgl_s;
    end
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q     <= '0;
      srst_ack <= 1'b0;
      cnt_q    <= DW'(LOAD_RESET);
      en_q     <= 1'b1;
      ks_q     <= KS_IDLE;
      rst_req  <= 1'b0;
    end else if (srst_evt) begin
      sc_q    <= SCW'(SRST_CYCLES);
      cnt_q   <= DW'(LOAD_RESET);
      en_q    <= 1'b1;
      ks_q    <= KS_IDLE;
      rst_req <= 1'b0;
    end else if (busy) begin
      sc_q    <= sc_q - 1'b1;
      if (sc_q == SCW'(1)) srst_ack <= ~srst_ack;
      cnt_q   <= DW'(LOAD_RESET);
      en_q    <= 1'b1;
      ks_q    <= KS_IDLE;
      rst_req <= 1'b0;
    end else begin
      if (key_evt) begin
        case (ks_q)
          KS_IDLE: begin
            if (key_data == DW'(KEY_STOP_A))     ks_q <= KS_STOP;
            else if (key_data == DW'(KEY_RUN_A)) ks_q <= KS_RUN;
          end
          KS_STOP: begin
            if (key_data == DW'(KEY_STOP_B)) en_q <= 1'b0;
            ks_q <= KS_IDLE;
          end
          KS_RUN: begin
            if (key_data == DW'(KEY_RUN_B)) en_q <= 1'b1;
            ks_q <= KS_IDLE;
          end
          default: ks_q <= KS_IDLE;
        endcase
      end
      rst_req <= 1'b0;
      if (en_q) begin
        if (cnt_q == '1) begin
          cnt_q   <= load_s;
          rst_req <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2: a stopped count holds its value
  p_stopped_frozen_r2: assert property (@(posedge tclk) disable iff (!rst_n)
    (!en_q && !busy && !srst_evt) |=> $stable(cnt_q));

  // R7: a request lasts one timer cycle unless reload is the top value
  p_pulse_single_r7: assert property (@(posedge tclk) disable iff (!rst_n)
    (rst_req && (load_s != '1) && !srst_evt) |=> !rst_req);

  // R6: leaving the soft-reset window finds the count armed at its default
  p_armed_after_srst_r6: assert property (@(posedge tclk) disable iff (!rst_n)
    $fell(busy) |-> (en_q && (cnt_q == DW'(LOAD_RESET))));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          DW          = 32,
  parameter int          AW          = 8,
  parameter logic [31:0] LOAD_RESET  = 32'hFFFF_FF00,
  parameter int          SRST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdt_reset_req
);
  logic          key_tgl, srst_tgl, key_ack, srst_ack;
  logic [1:0]    ack_s, tgl_s;
  logic [DW-1:0] key_data, load_q, load_s;

  wdt_bus_regs #(.DW(DW), .AW(AW), .LOAD_RESET(LOAD_RESET)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .key_tgl    (key_tgl),
    .key_data   (key_data),
    .key_ack_s  (ack_s[0]),
    .srst_tgl   (srst_tgl),
    .srst_ack_s (ack_s[1]),
    .load_q     (load_q)
  );

  wdt_sync2 #(.W(2)) u_sync_ack (
    .clk (clk), .rst_n (rst_n), .d ({srst_ack, key_ack}), .q (ack_s)
  );

  wdt_sync2 #(.W(2)) u_sync_tgl (
    .clk (tclk), .rst_n (rst_n), .d ({srst_tgl, key_tgl}), .q (tgl_s)
  );

  wdt_sync2 #(.W(DW)) u_sync_load (
    .clk (tclk), .rst_n (rst_n), .d (load_q), .q (load_s)
  );

  wdt_timer_core #(.DW(DW), .LOAD_RESET(LOAD_RESET), .SRST_CYCLES(SRST_CYCLES)) u_core (
    .tclk       (tclk),
    .rst_n      (rst_n),
    .key_tgl_s  (tgl_s[0]),
    .key_data   (key_data),
    .key_ack    (key_ack),
    .srst_tgl_s (tgl_s[1]),
    .srst_ack   (srst_ack),
    .load_s     (load_s),
    .rst_req    (wdt_reset_req)
  );
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
  logic        clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, rd_check = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_req;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  logic [31:0] mask_q[$];
  string       tag_q[$];
  logic        mon_fire = 1'b0;

  always #10 clk = ~clk;
  always #35 tclk = ~tclk;

  wdt_keyed u_dut (
    .clk (clk), .rst_n (rst_n), .tclk (tclk),
    .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .wdt_reset_req (wdt_reset_req)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read data returns
  always @(posedge clk) mon_fire <= bus_sel && !bus_we && rd_check;
  always @(negedge clk) begin
    if (mon_fire) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e, m;
        string t;
        e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
        check((bus_rdata & m) == (e & m), t, bus_rdata & m, e & m);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; rd_check = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; rd_check = 1'b0;
    @(negedge clk);
  endtask

  task automatic poll(input logic [7:0] a, input int bitn, input logic want, input string t);
    logic [31:0] d;
    int n;
    n = 0;
    do begin
      bus_read(a, d);
      n++;
    end while (d[bitn] != want && n < 200);
    check(d[bitn] == want, t, 32'(d[bitn]), 32'(want));
  endtask

  task automatic key_write(input logic [31:0] d);
    bus_write(8'h48, d);
    poll(8'h34, 4, 1'b0, "R4 pending clears");
  endtask

  task automatic wait_pulse(input int maxn, output int n);
    bit found;
    found = 0; n = 0;
    while (n < maxn && !found) begin
      @(negedge tclk);
      n++;
      if (wdt_reset_req) found = 1;
    end
    if (!found) n = -1;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    #100 rst_n = 1'b1;

    // reset state
    expect_read(8'h34, 32'h0, 32'h10, "R4 pending zero after reset");
    expect_read(8'h14, 32'h1, 32'h1, "R6 reset-done after hw reset");
    expect_read(8'h2C, 32'hFFFF_FF00, 32'hFFFF_FFFF, "R9 reload reset value");

    // R1: armed out of reset
    wait_pulse(300, n);
    check(n > 0, "R1 request without software action", 32'(n), 32'd256);
    @(negedge tclk);
    check(!wdt_reset_req, "R7 request one cycle wide", 32'(wdt_reset_req), 32'h0);
    wait_pulse(400, n);
    check(n + 1 == 256, "R7 default request spacing", 32'(n + 1), 32'd256);

    // R9: reload value
    bus_write(8'h2C, 32'hFFFF_FFC0);
    expect_read(8'h2C, 32'hFFFF_FFC0, 32'hFFFF_FFFF, "R9 reload readback");
    wait_pulse(400, n);
    wait_pulse(400, n);
    @(negedge tclk);
    wait_pulse(400, n);
    check(n + 1 == 64, "R9 short request spacing", 32'(n + 1), 32'd64);

    // R4 and R5: second key dropped while first still pending
    bus_write(8'h48, 32'h0000_AAAA);
    bus_write(8'h48, 32'h0000_5555);
    poll(8'h34, 4, 1'b0, "R5 pending clears");
    key_write(32'h0000_1234);
    wait_pulse(150, n);
    check(n > 0, "R5 dropped key leaves count running", 32'(n), 32'd64);

    // R3: wrong second word abandons
    bus_write(8'h48, 32'h0000_AAAA);
    expect_read(8'h34, 32'h10, 32'h10, "R4 pending set after key write");
    poll(8'h34, 4, 1'b0, "R4 pending clears");
    key_write(32'h0000_1111);
    key_write(32'h0000_5555);
    wait_pulse(150, n);
    check(n > 0, "R3 abandoned sequence keeps count running", 32'(n), 32'd64);

    // R2: proper stop
    key_write(32'h0000_AAAA);
    key_write(32'h0000_5555);
    wait_pulse(300, n);
    check(n == -1, "R2 stopped count gives no request", 32'(n), 32'hFFFF_FFFF);

    // R8: restart
    key_write(32'h0000_BBBB);
    key_write(32'h0000_4444);
    wait_pulse(150, n);
    check(n > 0, "R8 restarted count requests again", 32'(n), 32'd64);

    // R6: soft reset while stopped
    key_write(32'h0000_AAAA);
    key_write(32'h0000_5555);
    wait_pulse(150, n);
    check(n == -1, "R2 stopped before soft reset", 32'(n), 32'hFFFF_FFFF);
    bus_write(8'h10, 32'h0000_0002);
    expect_read(8'h14, 32'h0, 32'h1, "R6 reset-done low after request");
    poll(8'h14, 0, 1'b1, "R6 reset-done returns high");
    expect_read(8'h2C, 32'hFFFF_FF00, 32'hFFFF_FFFF, "R6 reload restored");
    wait_pulse(400, n);
    check(n > 0, "R6 soft reset re-arms count", 32'(n), 32'd256);
    @(negedge tclk);
    wait_pulse(400, n);
    check(n + 1 == 256, "R6 spacing after soft reset", 32'(n + 1), 32'd256);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule